// File: doc/BRIEF.md
# Active-Priority Register Access Window

This block is the register front end for the two banks of active-priority registers of one CPU interface. It also holds those registers. Bank 0 belongs to group 0 and bank 1 to group 1. A single-beat request bus carries a byte offset, a write flag, write data and a secure attribute. The block decodes the offset into one of two four-slot windows. It then applies the access rules for controller revision, group support and security, and returns registered read data on the following cycle.

A non-secure access to the group-0 window, when security extensions are present, does not reach bank 0. It is steered onto the upper part of bank 1, and the parameter `MIN_BPR` sets where. For small values of `MIN_BPR` the view is a whole register. For larger values it is a field inside bank-1 register 0, which is written by a read-modify-write. Accesses that the rules reject still complete with a normal response: a read returns zero and a write changes nothing.

The number of implemented registers per bank is 4 >> `MIN_BPR` for `MIN_BPR` below 2, and 1 otherwise. Slots above that count do not exist.

Top module: `apw_window`

## Requirements
- R1: After reset every implemented register in both banks holds 0, and `rsp_valid_o` is low until the first request.
- R2: Every request accepted with `req_valid_i` high is answered with `rsp_valid_o` high exactly one cycle later, and `rsp_valid_o` is low in every other cycle. A write response carries `rsp_rdata_o` = 0.
- R3: The group-0 window covers the byte offsets 0xD0, 0xD4, 0xD8 and 0xDC, and its slot is n = (offset - 0xD0)/4. A secure access, or any access made while `sec_ext_i` is 0, reads or writes all 32 bits of bank-0 register n.
- R4: The group-1 window covers the byte offsets 0xE0, 0xE4, 0xE8 and 0xEC, and its slot is n = (offset - 0xE0)/4. When `groups_en_i` is 1 and the access is not non-secure with `sec_ext_i` = 1, it reads or writes all 32 bits of bank-1 register n.
- R5: A group-1 window access made while `groups_en_i` = 0, or made non-secure while `sec_ext_i` = 1, reads 0 and leaves both banks unchanged.
- R6: In either window, an access with n at or above the implemented count, or with `ctl_rev_i` not equal to 2, reads 0 and leaves both banks unchanged.
- R7: With `MIN_BPR` = 0, a non-secure group-0 access with `sec_ext_i` = 1 to slot 0 or 1 reaches all of bank-1 register 2 or 3 respectively.
- R8: With `MIN_BPR` = 1, a non-secure group-0 access with `sec_ext_i` = 1 to slot 0 reaches all of bank-1 register 1.
- R9: With `MIN_BPR` = 2, a non-secure group-0 access with `sec_ext_i` = 1 to slot 0 reaches bits [31:16] of bank-1 register 0. A write stores `req_wdata_i[15:0]` there and keeps bits [15:0]. A read returns the field zero-extended.
- R10: With `MIN_BPR` = 3, the same access reaches bits [15:8] of bank-1 register 0. A write stores `req_wdata_i[7:0]` there and keeps all other bits. A read returns the field zero-extended.
- R11: A non-secure group-0 access with `sec_ext_i` = 1 to an in-range slot that the current `MIN_BPR` does not map reads 0 and leaves both banks unchanged.
- R12: An offset outside both windows, or one whose bits [1:0] are not 0, reads 0 and leaves both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| req_secure_i | input | 1 | 1 = secure access |
| sec_ext_i | input | 1 | Security extensions present |
| groups_en_i | input | 1 | Interrupt groups supported |
| ctl_rev_i | input | REV_W | Controller revision; only 2 enables the windows |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, valid with `rsp_valid_o` |

## Verification
The assertions check on every cycle the properties that can be seen without knowing which register a request targets. These are the one-cycle response timing and the zero data on write responses. They also cover zero reads for a wrong revision and for non-secure group-1 accesses, and frozen banks after any rejected write. Under a sub-word view they check that bits outside the field survive a write. Only the bench scenarios can show that data lands in the right slot of the right bank. The same holds for each `MIN_BPR` mapping returning what an earlier access through another path stored, and for values written while a gate was closed being absent once the gate reopens.

// File: rtl/apw_pkg.sv
package apw_pkg;
  localparam int DW        = 32;
  localparam int SLOTS     = 4;
  localparam int IDX_W     = $clog2(SLOTS);
  localparam int SHIFT_W   = $clog2(DW);
  localparam int REV_GOOD  = 2;
  localparam int G0_ROW    = 13;  // offset 0xD0 >> 4
  localparam int G1_ROW    = 14;  // offset 0xE0 >> 4

  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    logic               hit;
    logic               bank;
    logic [IDX_W-1:0]   idx;
    word_t              mask;
    logic [SHIFT_W-1:0] shift;
  } apw_sel_t;

  function automatic int num_apr(input int min_bpr);
    return (min_bpr < 2) ? (SLOTS >> min_bpr) : 1;
  endfunction
endpackage

// File: rtl/apw_decode.sv
module apw_decode
  import apw_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MIN_BPR = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secure_i,
  input  logic              sec_ext_i,
  input  logic              groups_en_i,
  input  logic              rev_ok_i,
  output apw_sel_t          sel_o
);
  localparam int NUM_APR = num_apr(MIN_BPR);
  localparam int ROW_W   = ADDR_W - 4;

  logic [IDX_W-1:0]   n;
  logic               aligned, in_g0, in_g1, in_range, ns_view;
  logic               v_hit;
  logic [IDX_W-1:0]   v_idx;
  word_t              v_mask;
  logic [SHIFT_W-1:0] v_shift;

  assign n        = addr_i[3:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_g0    = aligned && (addr_i[ADDR_W-1:4] == ROW_W'(G0_ROW));
  assign in_g1    = aligned && (addr_i[ADDR_W-1:4] == ROW_W'(G1_ROW));
  assign in_range = int'(n) < NUM_APR;
  assign ns_view  = sec_ext_i && !secure_i;

  // non-secure view of the group-0 window, picked by MIN_BPR
  generate
    if (MIN_BPR == 0) begin : g_view0
      assign v_hit   = !n[1];
      assign v_idx   = {1'b1, n[0]};
      assign v_mask  = '1;
      assign v_shift = '0;
    end else if (MIN_BPR == 1) begin : g_view1
      assign v_hit   = (n == '0);
      assign v_idx   = IDX_W'(1);
      assign v_mask  = '1;
      assign v_shift = '0;
    end else if (MIN_BPR == 2) begin : g_view2
      assign v_hit   = (n == '0);
      assign v_idx   = '0;
      assign v_mask  = 32'hFFFF_0000;
      assign v_shift = SHIFT_W'(16);
    end else begin : g_view3
      assign v_hit   = (n == '0);
      assign v_idx   = '0;
      assign v_mask  = 32'h0000_FF00;
      assign v_shift = SHIFT_W'(8);
    end
  endgenerate

  always_comb begin
    sel_o = '0;
    if (rev_ok_i && in_range) begin
      if (in_g0) begin
        if (ns_view) begin
          sel_o.hit   = v_hit;
          sel_o.bank  = 1'b1;
          sel_o.idx   = v_idx;
          sel_o.mask  = v_mask;
          sel_o.shift = v_shift;
        end else begin
          sel_o.hit  = 1'b1;
          sel_o.idx  = n;
          sel_o.mask = '1;
        end
      end else if (in_g1 && groups_en_i && !ns_view) begin
        sel_o.hit  = 1'b1;
        sel_o.bank = 1'b1;
        sel_o.idx  = n;
        sel_o.mask = '1;
      end
    end
  end
endmodule

// File: rtl/apw_bank.sv
module apw_bank
  import apw_pkg::*;
#(
  parameter int NUM_APR = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      bank_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  word_t                     mask_i,
  input  word_t                     data_i,
  output logic [1:0][SLOTS-1:0][DW-1:0] q_o
);
  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_APR) begin : g_impl
          always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
              q_o[b][i] <= '0;
            end else if (we_i && (bank_i == 1'(b)) && (idx_i == IDX_W'(i))) begin
              q_o[b][i] <= (q_o[b][i] & ~mask_i) | (data_i & mask_i);
            end
          end
        end else begin : g_absent
          assign q_o[b][i] = '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/apw_window.sv
module apw_window
  import apw_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int REV_W   = 4,
  parameter int MIN_BPR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic              req_secure_i,
  input  logic              sec_ext_i,
  input  logic              groups_en_i,
  input  logic [REV_W-1:0]  ctl_rev_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o
);
  localparam int NUM_APR = num_apr(MIN_BPR);

  apw_sel_t sel;
  logic     rev_ok, we, sel_hit;
  word_t    sel_word, rd_d;
  logic [1:0][SLOTS-1:0][DW-1:0] regs_q;
  logic [SLOTS-1:0][DW-1:0]      g0_q, g1_q;

  assign rev_ok = (ctl_rev_i == REV_W'(REV_GOOD));

  apw_decode #(.ADDR_W(ADDR_W), .MIN_BPR(MIN_BPR)) u_dec (
    .addr_i      (req_addr_i),
    .secure_i    (req_secure_i),
    .sec_ext_i   (sec_ext_i),
    .groups_en_i (groups_en_i),
    .rev_ok_i    (rev_ok),
    .sel_o       (sel)
  );

  assign we = req_valid_i && req_write_i && sel.hit;

  apw_bank #(.NUM_APR(NUM_APR)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .bank_i (sel.bank),
    .idx_i  (sel.idx),
    .mask_i (sel.mask),
    .data_i (req_wdata_i << sel.shift),
    .q_o    (regs_q)
  );

  assign g0_q     = regs_q[0];
  assign g1_q     = regs_q[1];
  assign sel_hit  = sel.hit;
  assign sel_word = sel.bank ? g1_q[sel.idx] : g0_q[sel.idx];
  assign rd_d     = (req_valid_i && !req_write_i && sel.hit)
                  ? ((sel_word & sel.mask) >> sel.shift) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/apw_window_chk.sv
module apw_window_chk
  import apw_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int REV_W   = 4,
  parameter int MIN_BPR = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_write_i,
  input logic [ADDR_W-1:0]        req_addr_i,
  input logic                     req_secure_i,
  input logic                     sec_ext_i,
  input logic [REV_W-1:0]         ctl_rev_i,
  input logic                     rsp_valid_o,
  input logic [31:0]              rsp_rdata_o,
  input logic                     sel_hit,
  input logic [SLOTS-1:0][DW-1:0] g0_q,
  input logic [SLOTS-1:0][DW-1:0] g1_q
);
  localparam int ROW_W = ADDR_W - 4;
  logic win_g0, win_g1, ns;
  assign win_g0 = (req_addr_i[1:0] == 2'b00) && (req_addr_i[ADDR_W-1:4] == ROW_W'(G0_ROW));
  assign win_g1 = (req_addr_i[1:0] == 2'b00) && (req_addr_i[ADDR_W-1:4] == ROW_W'(G1_ROW));
  assign ns     = sec_ext_i && !req_secure_i;

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R2
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R2
  write_rsp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_rdata_o == '0));
  // R6
  bad_rev_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && ctl_rev_i != REV_W'(REV_GOOD)) |=> (rsp_rdata_o == '0));
  // R5
  ns_g1_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && win_g1 && ns) |=> (rsp_rdata_o == '0));
  // R12
  dropped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !sel_hit) |=> ($stable(g0_q) && $stable(g1_q)));

  generate
    if (MIN_BPR >= 2) begin : g_field
      localparam logic [31:0] KEEP = (MIN_BPR == 2) ? 32'h0000_FFFF : 32'hFFFF_00FF;
      // R9 R10
      view_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && win_g0 && ns)
          |=> ((g1_q[0] & KEEP) == ($past(g1_q[0]) & KEEP)) && $stable(g0_q));
    end
  endgenerate
endmodule

bind apw_window apw_window_chk #(.ADDR_W(ADDR_W), .REV_W(REV_W), .MIN_BPR(MIN_BPR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_addr_i   (req_addr_i),
  .req_secure_i (req_secure_i),
  .sec_ext_i    (sec_ext_i),
  .ctl_rev_i    (ctl_rev_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .sel_hit      (sel_hit),
  .g0_q         (g0_q),
  .g1_q         (g1_q)
);

// File: tb/sim_apw_window.sv
`timescale 1ns/1ps
module sim_apw_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, sec = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        sec_ext = 1'b1, grp = 1'b1;
  logic [3:0]  rev = 4'd2;
  logic [3:0]       rv;
  logic [3:0][31:0] rd;

  int n_chk = 0, n_fail = 0;
  int mb_of[4] = '{2, 0, 1, 3};
  logic [31:0] mg0[4][4], mg1[4][4];
  logic [31:0] last[4];

  always #2 clk = ~clk;

  apw_window #(.MIN_BPR(2)) u0 (.clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_secure_i(sec), .sec_ext_i(sec_ext),
    .groups_en_i(grp), .ctl_rev_i(rev), .rsp_valid_o(rv[0]), .rsp_rdata_o(rd[0]));
  apw_window #(.MIN_BPR(0)) u1 (.clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_secure_i(sec), .sec_ext_i(sec_ext),
    .groups_en_i(grp), .ctl_rev_i(rev), .rsp_valid_o(rv[1]), .rsp_rdata_o(rd[1]));
  apw_window #(.MIN_BPR(1)) u2 (.clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_secure_i(sec), .sec_ext_i(sec_ext),
    .groups_en_i(grp), .ctl_rev_i(rev), .rsp_valid_o(rv[2]), .rsp_rdata_o(rd[2]));
  apw_window #(.MIN_BPR(3)) u3 (.clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_secure_i(sec), .sec_ext_i(sec_ext),
    .groups_en_i(grp), .ctl_rev_i(rev), .rsp_valid_o(rv[3]), .rsp_rdata_o(rd[3]));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic logic [31:0] model(input int d, input bit wr, input logic [11:0] a,
                                        input logic [31:0] wd, input bit s);
    int mb = mb_of[d];
    int na = (mb < 2) ? (4 >> mb) : 1;
    int off = int'(a);
    int n = (off >> 2) & 3;
    bit hit = 0, b = 0;
    int ix = 0, sh = 0;
    logic [31:0] m = '0;
    logic [31:0] cur;
    if (rev == 4'd2 && n < na && (off & 3) == 0) begin
      if (off >= 'hD0 && off <= 'hDC) begin
        if (sec_ext && !s) begin
          b = 1;
          case (mb)
            0: if (n < 2) begin hit = 1; ix = n + 2; m = '1; end
            1: if (n == 0) begin hit = 1; ix = 1; m = '1; end
            2: if (n == 0) begin hit = 1; m = 32'hFFFF0000; sh = 16; end
            default: if (n == 0) begin hit = 1; m = 32'h0000FF00; sh = 8; end
          endcase
        end else begin
          hit = 1; ix = n; m = '1;
        end
      end else if (off >= 'hE0 && off <= 'hEC && grp && !(sec_ext && !s)) begin
        hit = 1; b = 1; ix = n; m = '1;
      end
    end
    if (!hit) return '0;
    cur = b ? mg1[d][ix] : mg0[d][ix];
    if (wr) begin
      cur = (cur & ~m) | ((wd << sh) & m);
      if (b) mg1[d][ix] = cur; else mg0[d][ix] = cur;
      return '0;
    end
    return (cur & m) >> sh;
  endfunction

  task automatic op(input string tag, input bit wr, input logic [11:0] a,
                    input logic [31:0] wd, input bit s);
    logic [31:0] e[4];
    for (int d = 0; d < 4; d++) e[d] = model(d, wr, a, wd, s);
    @(negedge clk);
    valid = 1'b1; write = wr; addr = a; wdata = wd; sec = s;
    @(negedge clk);
    valid = 1'b0;
    for (int d = 0; d < 4; d++) begin
      chk($sformatf("R2 rsp strobe dut%0d", d), 32'(rv[d]), 32'd1);
      chk($sformatf("%s dut%0d addr %h", tag, d, a), rd[d], e[d]);
      last[d] = rd[d];
    end
    @(negedge clk);
    for (int d = 0; d < 4; d++) chk($sformatf("R2 idle dut%0d", d), 32'(rv[d]), 32'd0);
  endtask

  task automatic t_reset();
    for (int d = 0; d < 4; d++)
      for (int i = 0; i < 4; i++) begin mg0[d][i] = '0; mg1[d][i] = '0; end
    repeat (3) @(negedge clk);
    for (int d = 0; d < 4; d++) chk("R1 valid low in reset", 32'(rv[d]), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 4; d++) chk("R1 valid low after reset", 32'(rv[d]), 32'd0);
    for (int i = 0; i < 4; i++) begin
      op("R1 bank0 zero", 0, 12'hD0 + 12'(4*i), '0, 1);
      op("R1 bank1 zero", 0, 12'hE0 + 12'(4*i), '0, 1);
    end
  endtask

  task automatic t_direct();
    sec_ext = 1; grp = 1; rev = 2;
    for (int i = 0; i < 4; i++) op("R3 R6 secure g0 write", 1, 12'hD0 + 12'(4*i), 32'hA0A0_0000 + 32'(i), 1);
    for (int i = 0; i < 4; i++) op("R3 R6 secure g0 read", 0, 12'hD0 + 12'(4*i), '0, 1);
    op("R3 slot0 read", 0, 12'hD0, '0, 1);
    chk("R3 dut0 slot0 literal", last[0], 32'hA0A0_0000);
    op("R6 slot3 beyond count", 0, 12'hDC, '0, 1);
    chk("R6 dut2 slot3 reads 0", last[2], 32'h0);
    chk("R3 dut1 slot3 present", last[1], 32'hA0A0_0003);
  endtask

  task automatic t_group1();
    sec_ext = 1; grp = 1; rev = 2;
    for (int i = 0; i < 4; i++) op("R4 secure g1 write", 1, 12'hE0 + 12'(4*i), 32'h1234_5678 + 32'(i << 4), 1);
    for (int i = 0; i < 4; i++) op("R4 secure g1 read", 0, 12'hE0 + 12'(4*i), '0, 1);
    op("R5 ns g1 read", 0, 12'hE0, '0, 0);
    chk("R5 dut0 ns g1 reads 0", last[0], 32'h0);
    op("R5 ns g1 write", 1, 12'hE0, 32'hDEAD_BEEF, 0);
    op("R5 g1 after ns write", 0, 12'hE0, '0, 1);
    chk("R5 dut0 g1 unchanged", last[0], 32'h1234_5678);
    grp = 0;
    op("R5 no-groups read", 0, 12'hE4, '0, 1);
    op("R5 no-groups write", 1, 12'hE4, 32'hFFFF_FFFF, 1);
    grp = 1;
    op("R5 g1 after no-groups write", 0, 12'hE4, '0, 1);
    chk("R5 dut1 g1 slot1 unchanged", last[1], 32'h1234_5688);
  endtask

  task automatic t_view();
    sec_ext = 1; grp = 1; rev = 2;
    for (int i = 0; i < 4; i++) op("R7 R8 R9 R10 R11 ns g0 read", 0, 12'hD0 + 12'(4*i), '0, 0);
    chk("R9 dut0 ns read field", last[0], 32'h0);
    op("R9 R10 ns view read slot0", 0, 12'hD0, '0, 0);
    chk("R9 dut0 field [31:16]", last[0], 32'h0000_1234);
    chk("R10 dut3 field [15:8]", last[3], 32'h0000_0056);
    chk("R7 dut1 maps g1 slot2", last[1], 32'h1234_5698);
    chk("R8 dut2 maps g1 slot1", last[2], 32'h1234_5688);
    op("R7 R8 R9 R10 ns write slot0", 1, 12'hD0, 32'hFFFF_ABCD, 0);
    op("R7 R11 ns write slot1", 1, 12'hD4, 32'h5A5A_5A5A, 0);
    op("R11 ns write slot2", 1, 12'hD8, 32'h3C3C_3C3C, 0);
    op("R11 ns write slot3", 1, 12'hDC, 32'h6969_6969, 0);
    for (int i = 0; i < 4; i++) op("R7 R8 R9 R10 R11 g1 after view", 0, 12'hE0 + 12'(4*i), '0, 1);
    op("R9 R10 g1 slot0", 0, 12'hE0, '0, 1);
    chk("R9 dut0 deposit keeps low half", last[0], 32'hABCD_5678);
    chk("R10 dut3 deposit keeps others", last[3], 32'h1234_CD78);
    op("R9 R10 ns read after deposit", 0, 12'hD0, '0, 0);
    chk("R9 dut0 zero-extended", last[0], 32'h0000_ABCD);
    chk("R10 dut3 zero-extended", last[3], 32'h0000_00CD);
    op("R7 g1 slot3", 0, 12'hEC, '0, 1);
    chk("R7 dut1 slot1 view -> g1 slot3", last[1], 32'h5A5A_5A5A);
    op("R11 g0 slot2 untouched", 0, 12'hD8, '0, 1);
    chk("R11 dut1 g0 slot2 untouched", last[1], 32'hA0A0_0002);
  endtask

  task automatic t_nosec();
    sec_ext = 0; grp = 1; rev = 2;
    op("R3 no-secext ns write g0", 1, 12'hD0, 32'hCAFE_F00D, 0);
    op("R3 no-secext ns read g0", 0, 12'hD0, '0, 0);
    chk("R3 dut0 full word direct", last[0], 32'hCAFE_F00D);
    op("R4 no-secext ns read g1", 0, 12'hE0, '0, 0);
    chk("R4 dut3 g1 direct", last[3], 32'h1234_CD78);
    sec_ext = 1;
  endtask

  task automatic t_revision();
    rev = 4'd3;
    op("R6 bad rev write g0", 1, 12'hD0, 32'h1111_1111, 1);
    op("R6 bad rev write g1", 1, 12'hE0, 32'h2222_2222, 1);
    op("R6 bad rev read g0", 0, 12'hD0, '0, 1);
    chk("R6 dut0 bad rev reads 0", last[0], 32'h0);
    rev = 4'd2;
    op("R6 g0 after bad rev", 0, 12'hD0, '0, 1);
    chk("R6 dut0 g0 kept", last[0], 32'hCAFE_F00D);
    op("R6 g1 after bad rev", 0, 12'hE0, '0, 1);
    chk("R6 dut0 g1 kept", last[0], 32'hABCD_5678);
  endtask

  task automatic t_outside();
    rev = 2; sec_ext = 1; grp = 1;
    op("R12 write 0xCC", 1, 12'h0CC, 32'h7777_7777, 1);
    op("R12 write 0xF0", 1, 12'h0F0, 32'h7777_7777, 1);
    op("R12 write misaligned", 1, 12'h0D2, 32'h7777_7777, 1);
    op("R12 write 0x1D0", 1, 12'h1D0, 32'h7777_7777, 1);
    op("R12 read misaligned", 0, 12'h0E1, '0, 1);
    chk("R12 dut0 misaligned reads 0", last[0], 32'h0);
    op("R12 read 0x1E0", 0, 12'h1E0, '0, 1);
    for (int i = 0; i < 4; i++) begin
      op("R12 g0 intact", 0, 12'hD0 + 12'(4*i), '0, 1);
      op("R12 g1 intact", 0, 12'hE0 + 12'(4*i), '0, 1);
    end
  endtask

  initial begin
    t_reset();
    t_direct();
    t_group1();
    t_view();
    t_nosec();
    t_revision();
    t_outside();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule